// File: doc/BRIEF.md
# Three-Wire Addressed Configuration Loader

This block is the serial configuration port of a synthesizer-style device. An external host drives three wires: a serial clock, a data line and a load strobe. Bits are shifted into a 24-bit word, most significant bit first, one bit on each rising edge of the serial clock. When the load strobe rises, the two lowest bits of the word pick one of four configuration latches. The upper 22 bits of the word are written into that latch. The other latches are left as they were.

The three serial wires are asynchronous to the system clock. Each one passes through two flops, and its edges are then detected in the system clock domain. The block outputs the contents of all four latches. It also gives a power status, gated by a chip-enable input and by a power-down bit in the function latch, and a status multiplexer output. The multiplexer picks lock detect, the divided RF clock, the divided reference clock or a constant low, as set by a field of the function latch.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, all four latches read zero and mux_o is low.
- R2: Serial data is sampled on each rising edge of sclk_i, most significant bit first. The last 24 bits sampled form the word.
- R3: On a rising edge of sload_i, word bits [23:2] are written into the latch at index word[1:0]. Latch i appears on latches_o[22*i+21 : 22*i].
- R4: A load leaves the three latches that are not addressed unchanged.
- R5: Shifting bits with no rising edge of sload_i changes no latch.
- R6: Latch 2 is the function latch. Its payload bits [2:0] select mux_o: 0 gives low, 1 gives lock_i, 2 gives rf_div_i, 3 gives ref_div_i, and 4 to 7 give low.
- R7: pwr_up_o and cp_en_o are high only when chip_en_i is high and bit 3 of the function latch payload is 0.
- R8: While sload_i stays high, further shifting loads nothing. A new load needs sload_i to fall and then rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| sdata_i | input | 1 | Serial data (asynchronous) |
| sload_i | input | 1 | Load strobe (asynchronous) |
| chip_en_i | input | 1 | Chip enable |
| lock_i | input | 1 | Lock detect status |
| rf_div_i | input | 1 | Divided RF clock |
| ref_div_i | input | 1 | Divided reference clock |
| latches_o | output | 88 | Four latch payloads, latch 0 in the low bits |
| pwr_up_o | output | 1 | Device powered-up status |
| cp_en_o | output | 1 | Charge-pump output enable |
| mux_o | output | 1 | Selected status signal |

## Verification
A wrong shift order or a misplaced bit shows up on latches_o as a bad payload. It becomes visible a few system cycles after the load strobe rises, because the strobe's edge has to pass through the synchronizer first. A wrong address decode shows up in the same cycle as a change in the wrong lane, or as a neighbouring lane that was overwritten. A load that is retriggered or missed while the strobe is held leaves the previous payload or the new one in place, and the next readout shows which. Errors in the selector field or the power bit show up on mux_o and pwr_up_o one cycle after the function latch is written.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  localparam int WORD_W  = 24;
  localparam int ADDR_W  = 2;
  localparam int PAY_W   = WORD_W - ADDR_W;
  localparam int N_LATCH = 1 << ADDR_W;
  localparam int FUNC_IDX = 2;
  localparam int PD_BIT   = 3;
  localparam int SEL_W    = 3;

  typedef enum logic [SEL_W-1:0] {
    MUX_LOW  = 3'd0,
    MUX_LOCK = 3'd1,
    MUX_RF   = 3'd2,
    MUX_REF  = 3'd3
  } mux_sel_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[g];
        s2 <= s1;
      end
    end
    assign q_o[g] = s2;
  end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter
  import cfg_serial_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              sdata_s_i,
  input  logic              sload_s_i,
  output logic [WORD_W-1:0] word_o,
  output logic              load_pulse_o
);
  logic sclk_q, sload_q;
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      sload_q <= 1'b0;
      sr_q    <= '0;
    end else begin
      sclk_q  <= sclk_s_i;
      sload_q <= sload_s_i;
      if (sclk_s_i && !sclk_q) sr_q <= {sr_q[WORD_W-2:0], sdata_s_i};
    end
  end

  assign word_o       = sr_q;
  assign load_pulse_o = sload_s_i && !sload_q;
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
  import cfg_serial_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [WORD_W-1:0]        word_i,
  output logic [N_LATCH*PAY_W-1:0] latches_o
);
  logic [ADDR_W-1:0] addr;
  logic [PAY_W-1:0]  pay;
  assign addr = word_i[ADDR_W-1:0];
  assign pay  = word_i[WORD_W-1:ADDR_W];

  for (genvar g = 0; g < N_LATCH; g++) begin : g_lane
    logic [PAY_W-1:0] lat_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            lat_q <= '0;
      else if (load_i && addr == ADDR_W'(g))  lat_q <= pay;
    end
    assign latches_o[g*PAY_W +: PAY_W] = lat_q;
  end
endmodule

// File: rtl/cfg_status_mux.sv
module cfg_status_mux
  import cfg_serial_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic             lock_i,
  input  logic             rf_div_i,
  input  logic             ref_div_i,
  output logic             mux_o
);
  always_comb begin
    unique case (sel_i)
      MUX_LOCK: mux_o = lock_i;
      MUX_RF:   mux_o = rf_div_i;
      MUX_REF:  mux_o = ref_div_i;
      default:  mux_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_serial_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclk_i,
  input  logic                     sdata_i,
  input  logic                     sload_i,
  input  logic                     chip_en_i,
  input  logic                     lock_i,
  input  logic                     rf_div_i,
  input  logic                     ref_div_i,
  output logic [N_LATCH*PAY_W-1:0] latches_o,
  output logic                     pwr_up_o,
  output logic                     cp_en_o,
  output logic                     mux_o
);
  logic [2:0]        ser_s;
  logic [WORD_W-1:0] word;
  logic              load_pulse;
  logic [PAY_W-1:0]  func_lat;

  cfg_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sload_i, sdata_i, sclk_i}),
    .q_o   (ser_s)
  );

  cfg_shifter u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_s_i    (ser_s[0]),
    .sdata_s_i   (ser_s[1]),
    .sload_s_i   (ser_s[2]),
    .word_o      (word),
    .load_pulse_o(load_pulse)
  );

  cfg_latch_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_pulse),
    .word_i   (word),
    .latches_o(latches_o)
  );

  assign func_lat = latches_o[FUNC_IDX*PAY_W +: PAY_W];

  cfg_status_mux u_mux (
    .sel_i    (func_lat[SEL_W-1:0]),
    .lock_i   (lock_i),
    .rf_div_i (rf_div_i),
    .ref_div_i(ref_div_i),
    .mux_o    (mux_o)
  );

  // chip enable overrides the software power-down bit
  assign pwr_up_o = chip_en_i && !func_lat[PD_BIT];
  assign cp_en_o  = pwr_up_o;
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk
  import cfg_serial_pkg::*;
(
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     chip_en_i,
  input logic                     lock_i,
  input logic                     load_pulse,
  input logic [N_LATCH*PAY_W-1:0] latches_o,
  input logic                     pwr_up_o,
  input logic                     cp_en_o,
  input logic                     mux_o
);
  logic [N_LATCH*PAY_W-1:0] prev_q;
  logic [N_LATCH-1:0]       chg;
  logic [SEL_W-1:0]         sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= latches_o;
  end

  always_comb begin
    for (int i = 0; i < N_LATCH; i++)
      chg[i] = latches_o[i*PAY_W +: PAY_W] != prev_q[i*PAY_W +: PAY_W];
  end

  assign sel = latches_o[FUNC_IDX*PAY_W +: SEL_W];

  assert_one_lane_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chg));

  assert_load_needed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latches_o != prev_q) |-> $past(load_pulse));

  assert_pulse_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_pulse |=> !load_pulse);

  assert_ce_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_en_i |-> (!pwr_up_o && !cp_en_o));

  assert_mux_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == 3'd0 || sel[2]) |-> !mux_o);

  assert_mux_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == 3'd1) |-> (mux_o == lock_i));
endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .chip_en_i (chip_en_i),
  .lock_i    (lock_i),
  .load_pulse(load_pulse),
  .latches_o (latches_o),
  .pwr_up_o  (pwr_up_o),
  .cp_en_o   (cp_en_o),
  .mux_o     (mux_o)
);

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdata = 0, sload = 0, ce = 1;
  logic lock = 0, rfd = 0, refd = 0;
  logic [87:0] lat;
  logic pwr, cpen, muxo;
  logic [21:0] exp_l [4];
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  cfg_serial_loader uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sload_i(sload),
    .chip_en_i(ce), .lock_i(lock), .rf_div_i(rfd), .ref_div_i(refd),
    .latches_o(lat), .pwr_up_o(pwr), .cp_en_o(cpen), .mux_o(muxo));

  initial begin
    #2000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_word(logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      sdata = w[i]; wait_clk(3);
      sclk = 1;     wait_clk(3);
      sclk = 0;
    end
    wait_clk(3);
  endtask

  task automatic pulse_load();
    sload = 1; wait_clk(6);
    sload = 0; wait_clk(6);
  endtask

  function automatic logic exp_mux(logic [21:0] f);
    case (f[2:0])
      3'd1: return lock;
      3'd2: return rfd;
      3'd3: return refd;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_all(string req);
    for (int i = 0; i < 4; i++) chk(req, 32'(lat[i*22 +: 22]), 32'(exp_l[i]));
  endtask

  task automatic write_word(logic [21:0] p, logic [1:0] a);
    shift_word({p, a});
    pulse_load();
    exp_l[a] = p;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 4; i++) exp_l[i] = '0;
    wait_clk(4);
    // R1 reset state
    check_all("R1");
    chk("R1", 32'(muxo), 0);
    rst_n = 1;
    wait_clk(4);
    check_all("R1");

    // R2 R3: directed walking patterns, each address
    write_word(22'h200001, 2'd0); check_all("R2");
    write_word(22'h155555, 2'd1); check_all("R3");
    write_word(22'h000000, 2'd2); check_all("R3");
    write_word(22'h3ffffe, 2'd3); check_all("R2");

    // R3 R4 random loads
    for (int k = 0; k < 30; k++) begin
      logic [21:0] p = 22'($urandom);
      logic [1:0]  a = 2'($urandom);
      if (a == 2) p[3] = 0;
      write_word(p, a);
      check_all("R4");
    end

    // R5 shift with no load
    shift_word(24'hABCDEF);
    wait_clk(10);
    check_all("R5");

    // R8 load held high blocks new loads
    shift_word({22'h0a5a5a, 2'd1});
    sload = 1; wait_clk(6);
    exp_l[1] = 22'h0a5a5a;
    shift_word({22'h123456, 2'd1});
    wait_clk(6);
    check_all("R8");
    sload = 0; wait_clk(6);
    check_all("R8");
    pulse_load();
    exp_l[1] = 22'h123456;
    check_all("R8");

    // R6 mux codes with random status inputs
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 3; r++) begin
        {lock, rfd, refd} = 3'($urandom);
        write_word({18'($urandom), 1'b0, 3'(c)}, 2'd2);
        wait_clk(2);
        chk("R6", 32'(muxo), 32'(exp_mux(exp_l[2])));
      end
    end

    // R7 power gating
    write_word(22'h000001, 2'd2);
    ce = 1; wait_clk(2);
    chk("R7", 32'({pwr, cpen}), 32'(2'b11));
    ce = 0; wait_clk(2);
    chk("R7", 32'({pwr, cpen}), 0);
    ce = 1;
    write_word(22'h000008, 2'd2);
    wait_clk(2);
    chk("R7", 32'({pwr, cpen}), 0);
    write_word(22'h000000, 2'd2);
    wait_clk(2);
    chk("R7", 32'({pwr, cpen}), 32'(2'b11));
    check_all("R4");

    // R1 reset again clears
    rst_n = 0; wait_clk(2);
    for (int i = 0; i < 4; i++) exp_l[i] = '0;
    check_all("R1");
    chk("R1", 32'(muxo), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule